// File: doc/BRIEF.md
# Single-Wire Slave ROM Command Layer

This block sits between the bit-slot engine of a 1-Wire slave and the function-command layer above it. The bit-slot engine reports three things to it: a detected bus reset (after the presence response has gone out), each bit the master writes, and each read slot the master opens. The block answers every read slot with a flag that says whether to pull the line low.

After a reset, the block gathers an 8-bit ROM command, least-significant bit first, and executes it against a fixed 64-bit identity. That identity is built from three parameters: the family code in bits 7:0, the serial number in bits 55:8 and the check byte in bits 63:56. When a command completes successfully, the block raises `sel_o`, which enables the function layer until the next bus reset. Because the line is open-drain, a logic 0 is sent by pulling low and a logic 1 is sent by releasing the line.

The controller is a single state machine with nine states:

- `ST_WAIT_RST`: the power-up state, and the state after an unknown command. It ignores everything until a bus reset.
- `ST_CMD`: collects the command byte. From here the command selects the next state:
  - 33h goes to `ST_READ`.
  - 55h goes to `ST_MATCH`.
  - CCh goes to `ST_SELECTED`.
  - F0h goes to `ST_SRCH_TX`.
  - Any other byte goes to `ST_WAIT_RST`.
- `ST_READ`: sends the 64 identity bits and then moves to `ST_SELECTED`.
- `ST_MATCH`: compares 64 written bits. It moves to `ST_SELECTED` after the last bit, or to `ST_IDLE` at the first mismatch.
- Search runs through three states for each identity bit:
  - `ST_SRCH_TX` sends the bit.
  - `ST_SRCH_CP` sends its complement.
  - `ST_SRCH_RX` takes the master's bit. It moves to `ST_IDLE` on a mismatch, to `ST_SELECTED` after bit 63, and otherwise back to `ST_SRCH_TX`.
- `ST_SELECTED`: drives `sel_o` high.
- `ST_IDLE`: silent until a bus reset.

A bus reset moves every state to `ST_CMD`.

Top module: `owrom_cmd_ctrl`

## Requirements
- R1: After `rst_n` is released and before the first `bus_reset_i`, written bits and read slots have no effect. No command pulse occurs, `sel_o` stays 0, and read slots are answered with `rd_low_o`=0.
- R2: After a bus reset, the next 8 written bits form the command byte, LSB first. The one-cycle `cmd_pulse_o` appears in the cycle after the eighth bit, with `cmd_code_o` set as follows: 0 for 33h (read), 1 for 55h (match), 2 for CCh (skip) and 3 for F0h (search).
- R3: Any other command byte produces no pulse and returns the block to waiting for a reset. Further bytes are ignored until the next reset.
- R4: After the read command, the next 64 read slots return identity bits 0..63 in order, with `rd_low_o`=1 exactly for a 0 bit. The block is then selected.
- R5: After the match command, 64 written bits that equal identity bits 0..63 set `sel_o` in the cycle after the 64th bit, and not before.
- R6: During match, any written bit that differs from the identity leaves `sel_o` at 0. Read slots stay released until the next bus reset.
- R7: The skip command sets `sel_o` in the same cycle as its command pulse.
- R8: During search, each identity bit takes three slots:
  - a read slot that returns the bit;
  - a read slot that returns its complement;
  - a written bit.
  
  If all 64 written bits equal the identity, `sel_o` rises after the last one.
- R9: During search, a written bit that differs from the identity bit drops the block out. Later read slots are released and `sel_o` stays 0 until a bus reset.
- R10: A bus reset at any point aborts the current command. `sel_o` is 0 in the following cycle, and a new command byte is accepted.
- R11: Every read slot request is answered by `rd_done_o` in the next cycle. `rd_low_o` is 1 only together with `rd_done_o`, and is 0 when the block is selected.
- R12: `cmd_pulse_o` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_reset_i | input | 1 | One-cycle strobe: bus reset and presence completed |
| rx_valid_i | input | 1 | One-cycle strobe: master wrote a bit |
| rx_bit_i | input | 1 | Value of the written bit |
| rd_req_i | input | 1 | One-cycle strobe: master opened a read slot |
| rd_done_o | output | 1 | Read slot answer valid, one cycle after the request |
| rd_low_o | output | 1 | Pull the line low in this read slot (send 0) |
| cmd_pulse_o | output | 1 | One-cycle pulse when a known command is decoded |
| cmd_code_o | output | 2 | Decoded command: 0 read, 1 match, 2 skip, 3 search |
| sel_o | output | 1 | Device selected; enables the function layer |

## Verification
The hardest situation to reach is a drop-out in the middle of a search. To get there, the block must first pass reset, then receive a full command byte, and then go through several exact three-slot rounds, each bit with its read, complement read and write in order, before the master writes a wrong bit. The bench sends a correct search prefix and then corrupts a single chosen write. The identity is chosen so that the next bit is 0, which makes a device that failed to drop out visible, because it would pull the line low. Match failures and aborts in the middle of a read are reached in the same way: a full valid prefix is sent, followed by one disturbed slot.

// File: rtl/owrom_pkg.sv
package owrom_pkg;

    typedef enum logic [3:0] {
        ST_WAIT_RST,
        ST_CMD,
        ST_READ,
        ST_MATCH,
        ST_SRCH_TX,
        ST_SRCH_CP,
        ST_SRCH_RX,
        ST_SELECTED,
        ST_IDLE
    } owrom_state_e;

    typedef enum logic [1:0] {
        CMD_READ   = 2'd0,
        CMD_MATCH  = 2'd1,
        CMD_SKIP   = 2'd2,
        CMD_SEARCH = 2'd3
    } owrom_cmd_e;

    typedef struct packed {
        logic       ok;
        owrom_cmd_e cmd;
    } owrom_dec_t;

    localparam logic [7:0] OP_READ   = 8'h33;
    localparam logic [7:0] OP_MATCH  = 8'h55;
    localparam logic [7:0] OP_SKIP   = 8'hCC;
    localparam logic [7:0] OP_SEARCH = 8'hF0;

    function automatic owrom_dec_t owrom_decode(input logic [7:0] op);
        owrom_dec_t d;
        d.ok  = 1'b1;
        d.cmd = CMD_READ;
        unique case (op)
            OP_READ:   d.cmd = CMD_READ;
            OP_MATCH:  d.cmd = CMD_MATCH;
            OP_SKIP:   d.cmd = CMD_SKIP;
            OP_SEARCH: d.cmd = CMD_SEARCH;
            default:   d.ok  = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/owrom_cmd_shift.sv
module owrom_cmd_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] byte_nxt_o,
    output logic         done_o
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [W-1:0]  byte_q;
    logic [CW-1:0] cnt_q;

    // New bit enters at the top so the first bit ends in bit 0.
    assign byte_nxt_o = {bit_i, byte_q[W-1:1]};
    assign done_o     = shift_i && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q <= '0;
            cnt_q  <= '0;
        end else if (clr_i) begin
            byte_q <= '0;
            cnt_q  <= '0;
        end else if (shift_i) begin
            byte_q <= byte_nxt_o;
            cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/owrom_bit_idx.sv
module owrom_bit_idx #(
    parameter int N = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 inc_i,
    output logic [$clog2(N)-1:0] idx_o,
    output logic                 last_o
);
    localparam int IW = $clog2(N);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    logic [IW-1:0] idx_q;

    assign idx_o  = idx_q;
    assign last_o = (idx_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (clr_i) begin
            idx_q <= '0;
        end else if (inc_i) begin
            idx_q <= last_o ? '0 : idx_q + 1'b1;
        end
    end

endmodule

// File: rtl/owrom_cmd_ctrl.sv
module owrom_cmd_ctrl
    import owrom_pkg::*;
#(
    parameter logic [7:0]  FAMILY = 8'h24,
    parameter logic [47:0] SERIAL = 48'h0000_1A2B_3C4D,
    parameter logic [7:0]  CHECK  = 8'h9E
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_reset_i,
    input  logic       rx_valid_i,
    input  logic       rx_bit_i,
    input  logic       rd_req_i,
    output logic       rd_done_o,
    output logic       rd_low_o,
    output logic       cmd_pulse_o,
    output logic [1:0] cmd_code_o,
    output logic       sel_o
);
    localparam int            ID_W  = 64;
    localparam int            IDX_W = $clog2(ID_W);
    localparam logic [ID_W-1:0] ROM_ID = {CHECK, SERIAL, FAMILY};

    owrom_state_e state_q, state_d;

    logic             sh_clr, sh_en, cmd_done;
    logic [7:0]       cmd_byte;
    logic             idx_clr, idx_inc, idx_last;
    logic [IDX_W-1:0] idx;
    logic             id_bit, tx_low;
    owrom_dec_t       dec;

    logic       rd_done_q, rd_low_q, cmd_pulse_q, sel_q;
    logic [1:0] cmd_code_q;

    owrom_cmd_shift #(.W(8)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (sh_clr),
        .shift_i    (sh_en),
        .bit_i      (rx_bit_i),
        .byte_nxt_o (cmd_byte),
        .done_o     (cmd_done)
    );

    owrom_bit_idx #(.N(ID_W)) u_idx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (idx_clr),
        .inc_i  (idx_inc),
        .idx_o  (idx),
        .last_o (idx_last)
    );

    assign id_bit = ROM_ID[idx];
    assign dec    = owrom_decode(cmd_byte);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        sh_clr  = 1'b0;
        sh_en   = 1'b0;
        idx_clr = 1'b0;
        idx_inc = 1'b0;
        if (bus_reset_i) begin
            state_d = ST_CMD;
            sh_clr  = 1'b1;
            idx_clr = 1'b1;
        end else begin
            unique case (state_q)
                ST_CMD: begin
                    if (rx_valid_i) begin
                        sh_en = 1'b1;
                        if (cmd_done) begin
                            idx_clr = 1'b1;
                            if (!dec.ok) begin
                                state_d = ST_WAIT_RST;
                            end else begin
                                unique case (dec.cmd)
                                    CMD_READ:   state_d = ST_READ;
                                    CMD_MATCH:  state_d = ST_MATCH;
                                    CMD_SKIP:   state_d = ST_SELECTED;
                                    CMD_SEARCH: state_d = ST_SRCH_TX;
                                    default:    state_d = ST_WAIT_RST;
                                endcase
                            end
                        end
                    end
                end
                ST_READ: begin
                    if (rd_req_i) begin
                        idx_inc = 1'b1;
                        if (idx_last) state_d = ST_SELECTED;
                    end
                end
                ST_MATCH: begin
                    if (rx_valid_i) begin
                        if (rx_bit_i != id_bit) begin
                            state_d = ST_IDLE;
                        end else begin
                            idx_inc = 1'b1;
                            if (idx_last) state_d = ST_SELECTED;
                        end
                    end
                end
                ST_SRCH_TX: if (rd_req_i) state_d = ST_SRCH_CP;
                ST_SRCH_CP: if (rd_req_i) state_d = ST_SRCH_RX;
                ST_SRCH_RX: begin
                    if (rx_valid_i) begin
                        if (rx_bit_i != id_bit) begin
                            state_d = ST_IDLE;
                        end else begin
                            idx_inc = 1'b1;
                            state_d = idx_last ? ST_SELECTED : ST_SRCH_TX;
                        end
                    end
                end
                ST_WAIT_RST, ST_SELECTED, ST_IDLE: state_d = state_q;
                default: state_d = ST_WAIT_RST;
            endcase
        end
    end

    // What the line should carry in a read slot of the current state
    always_comb begin
        unique case (state_q)
            ST_READ, ST_SRCH_TX: tx_low = ~id_bit;
            ST_SRCH_CP:          tx_low = id_bit;
            default:             tx_low = 1'b0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT_RST;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_done_q   <= 1'b0;
            rd_low_q    <= 1'b0;
            cmd_pulse_q <= 1'b0;
            cmd_code_q  <= 2'd0;
            sel_q       <= 1'b0;
        end else begin
            rd_done_q   <= rd_req_i;
            rd_low_q    <= rd_req_i && !bus_reset_i && tx_low;
            cmd_pulse_q <= !bus_reset_i && (state_q == ST_CMD) && rx_valid_i
                           && cmd_done && dec.ok;
            if (!bus_reset_i && (state_q == ST_CMD) && rx_valid_i && cmd_done && dec.ok)
                cmd_code_q <= dec.cmd;
            sel_q       <= (state_d == ST_SELECTED);
        end
    end

    assign rd_done_o   = rd_done_q;
    assign rd_low_o    = rd_low_q;
    assign cmd_pulse_o = cmd_pulse_q;
    assign cmd_code_o  = cmd_code_q;
    assign sel_o       = sel_q;

    AST_NO_CMD_BEFORE_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_RST && !bus_reset_i) |=> !cmd_pulse_o); // R1

    AST_RST_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_i |=> !sel_o); // R10

    AST_MATCH_FAIL_NOSEL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MATCH && rx_valid_i && !bus_reset_i && (rx_bit_i != id_bit))
        |=> !sel_o); // R6

    AST_SRCH_FAIL_NOSEL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SRCH_RX && rx_valid_i && !bus_reset_i && (rx_bit_i != id_bit))
        |=> !sel_o); // R9

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !bus_reset_i) |=> !rd_low_o); // R6

    AST_LOW_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_low_o |-> rd_done_o); // R11

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pulse_o |=> !cmd_pulse_o); // R12

    AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o && !bus_reset_i) |=> sel_o); // R7

endmodule

// File: tb/owrom_cmd_ctrl_tb.sv
module owrom_cmd_ctrl_tb;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 100000;

    localparam logic [7:0]  T_FAM = 8'h24;
    localparam logic [47:0] T_SER = 48'h0000_1A2B_3C4D;
    localparam logic [7:0]  T_CHK = 8'h9E;
    localparam logic [63:0] T_ID  = {T_CHK, T_SER, T_FAM};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_reset_i = 1'b0, rx_valid_i = 1'b0, rx_bit_i = 1'b0, rd_req_i = 1'b0;
    logic rd_done_o, rd_low_o, cmd_pulse_o, sel_o;
    logic [1:0] cmd_code_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    owrom_cmd_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_reset_i (bus_reset_i),
        .rx_valid_i  (rx_valid_i),
        .rx_bit_i    (rx_bit_i),
        .rd_req_i    (rd_req_i),
        .rd_done_o   (rd_done_o),
        .rd_low_o    (rd_low_o),
        .cmd_pulse_o (cmd_pulse_o),
        .cmd_code_o  (cmd_code_o),
        .sel_o       (sel_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_rst();
        @(negedge clk) bus_reset_i = 1'b1;
        @(negedge clk) bus_reset_i = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk) begin rx_valid_i = 1'b1; rx_bit_i = b; end
        @(negedge clk) rx_valid_i = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic read_slot(output logic low);
        @(negedge clk) rd_req_i = 1'b1;
        @(negedge clk) rd_req_i = 1'b0;
        check("R11 rd_done", rd_done_o, 1);
        low = rd_low_o;
    endtask

    task automatic t_reset_state();
        check("R1 sel after rst", sel_o, 0);
        check("R1 pulse after rst", cmd_pulse_o, 0);
        check("R11 done after rst", rd_done_o, 0);
    endtask

    task automatic t_before_reset();
        logic low;
        send_byte(8'hCC);
        check("R1 no pulse pre-reset", cmd_pulse_o, 0);
        check("R1 no sel pre-reset", sel_o, 0);
        read_slot(low);
        check("R1 released pre-reset", low, 0);
    endtask

    task automatic t_skip();
        logic low;
        bus_rst();
        send_byte(8'hCC);
        check("R2 skip pulse", cmd_pulse_o, 1);
        check("R2 skip code", cmd_code_o, 2);
        check("R7 skip sel", sel_o, 1);
        @(negedge clk);
        check("R12 pulse one cycle", cmd_pulse_o, 0);
        read_slot(low);
        check("R11 released when selected", low, 0);
        bus_rst();
        check("R10 reset deselects", sel_o, 0);
    endtask

    task automatic t_read();
        logic low;
        bus_rst();
        send_byte(8'h33);
        check("R2 read pulse", cmd_pulse_o, 1);
        check("R2 read code", cmd_code_o, 0);
        for (int i = 0; i < 64; i++) begin
            read_slot(low);
            check($sformatf("R4 read bit %0d", i), low, !T_ID[i]);
        end
        check("R4 selected after read", sel_o, 1);
    endtask

    task automatic t_match(input int bad_bit);
        logic low;
        bus_rst();
        send_byte(8'h55);
        check("R2 match code", cmd_code_o, 1);
        for (int i = 0; i < 64; i++) begin
            send_bit((i == bad_bit) ? !T_ID[i] : T_ID[i]);
            if (i == 62) check("R5 not yet selected", sel_o, 0);
        end
        if (bad_bit < 0) begin
            check("R5 match selects", sel_o, 1);
        end else begin
            check("R6 mismatch no sel", sel_o, 0);
            read_slot(low);
            check("R6 silent after mismatch", low, 0);
        end
    endtask

    task automatic t_search(input int bad_bit);
        logic a, b;
        bus_rst();
        send_byte(8'hF0);
        check("R2 search code", cmd_code_o, 3);
        for (int i = 0; i < 64; i++) begin
            read_slot(a);
            read_slot(b);
            if (bad_bit >= 0 && i > bad_bit) begin
                check("R9 released after dropout", a, 0);
                check("R9 released comp after dropout", b, 0);
                break;
            end
            check($sformatf("R8 search bit %0d", i), a, !T_ID[i]);
            check($sformatf("R8 search comp %0d", i), b, T_ID[i]);
            send_bit((i == bad_bit) ? !T_ID[i] : T_ID[i]);
        end
        if (bad_bit < 0) check("R8 search selects", sel_o, 1);
        else             check("R9 dropout no sel", sel_o, 0);
    endtask

    task automatic t_unknown();
        bus_rst();
        send_byte(8'hA5);
        check("R3 no pulse unknown", cmd_pulse_o, 0);
        send_byte(8'hCC);
        check("R3 later byte ignored", cmd_pulse_o, 0);
        check("R3 not selected", sel_o, 0);
    endtask

    task automatic t_abort_read();
        logic low;
        bus_rst();
        send_byte(8'h33);
        for (int i = 0; i < 10; i++) read_slot(low);
        bus_rst();
        send_byte(8'hCC);
        check("R10 new command after abort", cmd_pulse_o, 1);
        check("R10 code after abort", cmd_code_o, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_before_reset();
        t_skip();
        t_read();
        t_match(-1);
        t_match(20);
        t_search(-1);
        t_search(5);
        t_unknown();
        t_abort_read();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=done", WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule